// File: doc/BRIEF.md
# Coherence Update Line Merge Engine

This block applies a coherence update to a cache line that is already resident in a cache data array. A caller supplies the new data for every word of the line, one byte-enable mask per word, the set and way of the line, and a one-cycle start pulse. The block captures that update into its own target buffer. It then walks the line word by word. For each word it reads the cached value from the data array, merges in the new bytes and writes the merged word back.

The data array port is a plain synchronous single port with a one-cycle read latency. Each word costs two cycles: a read cycle, then a write cycle for the same word. A mode input chosen at start selects one of two walks. The full walk visits every word. The sparse walk visits only the words whose mask has at least one bit set. A single-cycle done pulse closes every update.

The line length is the larger of the instruction-side and data-side words-per-line parameters, so one engine can serve either cache.

Top module: `line_merge_engine`

## Requirements
- R1: The written word takes byte b (bits 8b+7..8b) from the update data wherever bit b of that word's byte-enable mask is 1, and keeps the cached byte from the array wherever the bit is 0.
- R2: Each visited word is read in one cycle (arr_en_o=1, arr_we_o=0) and written in the next cycle (arr_en_o=1, arr_we_o=1) with the same word index, set and way. Visited words go in ascending index order.
- R3: With skip_i=1 at start, only words whose 4-bit mask is non-zero are read or written. Words with an all-zero mask cause no array access.
- R4: If start is accepted at clock edge E and k words are visited (k>0), done_o is 1 for exactly one cycle: the (2k+1)-th cycle after E, which directly follows the last write.
- R5: With skip_i=1 and every mask zero, done_o is 1 in the first cycle after the accepting edge, with no array access.
- R6: Start is ignored while an update is in progress, including the done cycle. It loads no new set, way, data or mask, and it starts no extra access.
- R7: The line length is max(IC_WORDS, DC_WORDS). In the full walk (skip_i=0) all of these words are written, including words with an all-zero mask, which are rewritten unchanged.
- R8: During and after reset the block is idle: done_o=0 and arr_en_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an update (taken only when idle) |
| skip_i | input | 1 | 1 = sparse walk over words with a non-zero mask, 0 = full walk |
| set_i | input | SET_W | Set index of the target line |
| way_i | input | WAY_W | Way index of the target line |
| upd_data_i | input | WORDS*DATA_W | Update data, word w at bits w*DATA_W upward |
| upd_be_i | input | WORDS*BE_W | Byte-enable masks, word w at bits w*BE_W upward |
| arr_en_o | output | 1 | Data array access enable |
| arr_we_o | output | 1 | Data array write (1) or read (0) |
| arr_set_o | output | SET_W | Data array set index |
| arr_way_o | output | WAY_W | Data array way index |
| arr_word_o | output | IDX_W | Word index within the line |
| arr_wdata_o | output | DATA_W | Merged write data |
| arr_rdata_i | input | DATA_W | Read data, valid the cycle after a read |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a second start request that arrives while a walk is running or while done is high. An ignored request leaves no trace at the ports unless the bench looks for stray array accesses and for writes that carry the wrong set or data. The bench therefore pulses start with a different set, mode and data in the middle of a full walk and again in the done cycle. A scoreboard then requires that every access matches the first update only, and that no access follows the done cycle. Sparse masks that hold only the first word, only the last word, or no word at all reach the edges of the next-word search.

// File: rtl/line_merge_pkg.sv
package line_merge_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic we;
    } arr_cmd_t;

    function automatic int larger(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/line_merge_buf.sv
module line_merge_buf
    import line_merge_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int SET_W  = 6,
    parameter int WAY_W  = 2,
    localparam int BE_W  = DATA_W / BYTE_W,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    skip_i,
    input  logic [SET_W-1:0]        set_i,
    input  logic [WAY_W-1:0]        way_i,
    input  logic [WORDS*DATA_W-1:0] data_i,
    input  logic [WORDS*BE_W-1:0]   be_i,
    input  logic [IDX_W-1:0]        sel_i,
    output logic [SET_W-1:0]        set_q_o,
    output logic [WAY_W-1:0]        way_q_o,
    output logic                    skip_q_o,
    output logic [WORDS-1:0]        live_in_o,
    output logic [WORDS-1:0]        live_q_o,
    output logic [DATA_W-1:0]       sel_data_o,
    output logic [BE_W-1:0]         sel_be_o
);

    logic [DATA_W-1:0] data_q [WORDS];
    logic [BE_W-1:0]   be_q   [WORDS];
    logic [SET_W-1:0]  set_q;
    logic [WAY_W-1:0]  way_q;
    logic              skip_q;
    logic [WORDS-1:0]  live_q;

    // a word is visited in the full walk, or when its mask is non-zero
    for (genvar w = 0; w < WORDS; w++) begin : g_live
        assign live_in_o[w] = !skip_i || (be_i[w*BE_W +: BE_W] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q  <= '0;
            way_q  <= '0;
            skip_q <= 1'b0;
            live_q <= '0;
            for (int w = 0; w < WORDS; w++) begin
                data_q[w] <= '0;
                be_q[w]   <= '0;
            end
        end else if (load_i) begin
            set_q  <= set_i;
            way_q  <= way_i;
            skip_q <= skip_i;
            live_q <= live_in_o;
            for (int w = 0; w < WORDS; w++) begin
                data_q[w] <= data_i[w*DATA_W +: DATA_W];
                be_q[w]   <= be_i[w*BE_W +: BE_W];
            end
        end
    end

    assign set_q_o    = set_q;
    assign way_q_o    = way_q;
    assign skip_q_o   = skip_q;
    assign live_q_o   = live_q;
    assign sel_data_o = data_q[sel_i];
    assign sel_be_o   = be_q[sel_i];

endmodule

// File: rtl/line_merge_seq.sv
module line_merge_seq
    import line_merge_pkg::*;
#(
    parameter int WORDS  = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WORDS-1:0] live_in_i,
    input  logic [WORDS-1:0] live_q_i,
    output logic             load_o,
    output logic             busy_o,
    output arr_cmd_t         cmd_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W:0]   first_s;
    logic [IDX_W:0]   after_s;

    // lowest marked word at or above 'from'; top bit flags a hit
    function automatic logic [IDX_W:0] seek(input logic [WORDS-1:0] live, input int from);
        logic [IDX_W:0] r;
        r = '0;
        for (int w = WORDS - 1; w >= 0; w--) begin
            if (live[w] && (w >= from)) r = {1'b1, IDX_W'(w)};
        end
        return r;
    endfunction

    always_comb begin
        first_s = seek(live_in_i, 0);
        after_s = seek(live_q_i, int'(idx_q) + 1);
    end

    assign load_o = start_i && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (first_s[IDX_W]) begin
                            state_q <= ST_READ;
                            idx_q   <= first_s[IDX_W-1:0];
                        end else begin
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_READ: state_q <= ST_WRITE;
                ST_WRITE: begin
                    if (after_s[IDX_W]) begin
                        state_q <= ST_READ;
                        idx_q   <= after_s[IDX_W-1:0];
                    end else begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_o.en = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign cmd_o.we = (state_q == ST_WRITE);
    assign idx_o    = idx_q;
    assign done_o   = (state_q == ST_FIN);
    assign busy_o   = (state_q != ST_IDLE);

    // R2: a read is always followed by the write of the same word
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (cmd_o.en && !cmd_o.we) |=> (cmd_o.en && cmd_o.we && $stable(idx_o)));

    // R4: done lasts a single cycle
    a_r4_done_once: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/line_merge_mix.sv
module line_merge_mix
    import line_merge_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [BE_W-1:0]   be_i,
    output logic [DATA_W-1:0] mix_o
);

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign mix_o[b*BYTE_W +: BYTE_W] = be_i[b] ? new_i[b*BYTE_W +: BYTE_W]
                                                   : old_i[b*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/line_merge_engine.sv
module line_merge_engine
    import line_merge_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IC_WORDS = 8,
    parameter int DC_WORDS = 16,
    parameter int SETS     = 64,
    parameter int WAYS     = 4,
    localparam int WORDS   = larger(IC_WORDS, DC_WORDS),
    localparam int BE_W    = DATA_W / BYTE_W,
    localparam int IDX_W   = $clog2(WORDS),
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    skip_i,
    input  logic [SET_W-1:0]        set_i,
    input  logic [WAY_W-1:0]        way_i,
    input  logic [WORDS*DATA_W-1:0] upd_data_i,
    input  logic [WORDS*BE_W-1:0]   upd_be_i,
    output logic                    arr_en_o,
    output logic                    arr_we_o,
    output logic [SET_W-1:0]        arr_set_o,
    output logic [WAY_W-1:0]        arr_way_o,
    output logic [IDX_W-1:0]        arr_word_o,
    output logic [DATA_W-1:0]       arr_wdata_o,
    input  logic [DATA_W-1:0]       arr_rdata_i,
    output logic                    done_o
);

    logic             load;
    logic             busy;
    arr_cmd_t         cmd;
    logic [IDX_W-1:0] idx;
    logic [WORDS-1:0] live_in;
    logic [WORDS-1:0] live_q;
    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;
    logic             skip_q;
    logic [DATA_W-1:0] sel_data;
    logic [BE_W-1:0]   sel_be;

    line_merge_buf #(
        .WORDS (WORDS),
        .DATA_W(DATA_W),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .skip_i    (skip_i),
        .set_i     (set_i),
        .way_i     (way_i),
        .data_i    (upd_data_i),
        .be_i      (upd_be_i),
        .sel_i     (idx),
        .set_q_o   (set_q),
        .way_q_o   (way_q),
        .skip_q_o  (skip_q),
        .live_in_o (live_in),
        .live_q_o  (live_q),
        .sel_data_o(sel_data),
        .sel_be_o  (sel_be)
    );

    line_merge_seq #(
        .WORDS(WORDS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .live_in_i(live_in),
        .live_q_i (live_q),
        .load_o   (load),
        .busy_o   (busy),
        .cmd_o    (cmd),
        .idx_o    (idx),
        .done_o   (done_o)
    );

    line_merge_mix #(
        .DATA_W(DATA_W)
    ) u_mix (
        .old_i(arr_rdata_i),
        .new_i(sel_data),
        .be_i (sel_be),
        .mix_o(arr_wdata_o)
    );

    assign arr_en_o   = cmd.en;
    assign arr_we_o   = cmd.we;
    assign arr_set_o  = set_q;
    assign arr_way_o  = way_q;
    assign arr_word_o = idx;

    // R3: the sparse walk never touches a word with an empty mask
    a_r3_skip_live: assert property (@(posedge clk) disable iff (rst)
        (arr_en_o && skip_q) |-> (sel_be != '0));

    // R6: a start seen while busy leaves the captured target alone
    a_r6_hold_target: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy) |=> ($stable(arr_set_o) && $stable(arr_way_o)));

    // R5: the done cycle carries no array access
    a_r5_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !arr_en_o);

endmodule

// File: tb/sim_line_merge_engine.sv
module sim_line_merge_engine;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 32;
    localparam int ICW  = 4;
    localparam int DCW  = 8;
    localparam int LINE = (ICW > DCW) ? ICW : DCW;
    localparam int NSET = 4;
    localparam int NWAY = 2;
    localparam int BEW  = DW / 8;
    localparam int IW   = $clog2(LINE);
    localparam int SW   = $clog2(NSET);
    localparam int WW   = $clog2(NWAY);
    localparam int MEMN = NSET * NWAY * LINE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic skip_i = 1'b0;
    logic [SW-1:0] set_i = '0;
    logic [WW-1:0] way_i = '0;
    logic [LINE*DW-1:0] upd_data_i = '0;
    logic [LINE*BEW-1:0] upd_be_i = '0;
    logic arr_en_o, arr_we_o, done_o;
    logic [SW-1:0] arr_set_o;
    logic [WW-1:0] arr_way_o;
    logic [IW-1:0] arr_word_o;
    logic [DW-1:0] arr_wdata_o;
    logic [DW-1:0] arr_rdata_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_merge_engine #(
        .DATA_W(DW), .IC_WORDS(ICW), .DC_WORDS(DCW), .SETS(NSET), .WAYS(NWAY)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .skip_i(skip_i),
        .set_i(set_i), .way_i(way_i), .upd_data_i(upd_data_i), .upd_be_i(upd_be_i),
        .arr_en_o(arr_en_o), .arr_we_o(arr_we_o), .arr_set_o(arr_set_o),
        .arr_way_o(arr_way_o), .arr_word_o(arr_word_o), .arr_wdata_o(arr_wdata_o),
        .arr_rdata_i(arr_rdata_i), .done_o(done_o)
    );

    // data array model: one-cycle read latency
    logic [DW-1:0] mem [MEMN];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= (i * 32'h0103_0507) ^ 32'hC35A_0000;
            arr_rdata_i <= '0;
        end else if (arr_en_o) begin
            if (arr_we_o) mem[(int'(arr_set_o) * NWAY + int'(arr_way_o)) * LINE + int'(arr_word_o)] <= arr_wdata_o;
            else arr_rdata_i <= mem[(int'(arr_set_o) * NWAY + int'(arr_way_o)) * LINE + int'(arr_word_o)];
        end
    end

    int total = 0;
    int bad = 0;

    typedef struct {
        int            word;
        logic [DW-1:0] data;
    } exp_t;
    exp_t exp_q[$];
    int cur_set = 0;
    int cur_way = 0;
    int wr_seen = 0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [BEW-1:0] m);
        logic [DW-1:0] r;
        for (int b = 0; b < BEW; b++) r[b*8 +: 8] = m[b] ? n[b*8 +: 8] : o[b*8 +: 8];
        return r;
    endfunction

    // monitor: every access must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && arr_en_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected array access word", longint'(arr_word_o), -1);
            end else if (!arr_we_o) begin
                chk(int'(arr_word_o) == exp_q[0].word, "R3", "read word", longint'(arr_word_o), exp_q[0].word);
            end else begin
                chk(int'(arr_word_o) == exp_q[0].word, "R2", "write word", longint'(arr_word_o), exp_q[0].word);
                chk(arr_wdata_o == exp_q[0].data, "R1", "merged data", longint'(arr_wdata_o), longint'(exp_q[0].data));
                chk(int'(arr_set_o) == cur_set && int'(arr_way_o) == cur_way, "R2", "set/way",
                    longint'({arr_set_o, arr_way_o}), longint'(cur_set * NWAY + cur_way));
                void'(exp_q.pop_front());
                wr_seen++;
            end
        end
    end

    // driver: builds expectations, issues start, times done
    task automatic run_update(input int s, input int w, input bit skip,
                              input logic [LINE*BEW-1:0] be, input int seed,
                              input int intrude_at, input bit intrude_done);
        logic [LINE*DW-1:0] d;
        int k = 0;
        int c = 0;
        bit seen_done = 0;
        for (int i = 0; i < LINE; i++) d[i*DW +: DW] = (seed + i) * 32'h1F2E_3D4B;
        for (int i = 0; i < LINE; i++) begin
            if (!skip || be[i*BEW +: BEW] != '0) begin
                exp_t e;
                e.word = i;
                e.data = merge(mem[(s * NWAY + w) * LINE + i], d[i*DW +: DW], be[i*BEW +: BEW]);
                exp_q.push_back(e);
                k++;
            end
        end
        cur_set = s; cur_way = w; wr_seen = 0;
        set_i = SW'(s); way_i = WW'(w); skip_i = skip; upd_data_i = d; upd_be_i = be;
        start_i = 1'b1;
        while (!seen_done && c < 4 * LINE) begin
            @(negedge clk);
            c++;
            start_i = 1'b0;
            if (done_o) seen_done = 1;
            if (c == intrude_at || (intrude_done && seen_done)) begin
                // a second request that must be ignored
                set_i = SW'(s + 1); way_i = WW'(w + 1); skip_i = ~skip;
                upd_data_i = ~d; upd_be_i = ~be; start_i = 1'b1;
            end
        end
        chk(seen_done, "R4", "done seen", longint'(seen_done), 1);
        chk(c == 2 * k + 1, (k == 0) ? "R5" : "R4", "done cycle", c, 2 * k + 1);
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o, "R4", "done single pulse", longint'(done_o), 0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "pending expected accesses", exp_q.size(), 0);
        chk(wr_seen == k, skip ? "R3" : "R7", "write count", wr_seen, k);
        exp_q.delete();
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        chk(!done_o && !arr_en_o, "R8", "idle in reset", longint'({done_o, arr_en_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !arr_en_o, "R8", "idle after reset", longint'({done_o, arr_en_o}), 0);

        // R1 R2 R7: full walk, mixed masks including empty ones
        run_update(1, 0, 1'b0, 32'h0F30_5A01, 3, 0, 0);
        // R3: sparse walk, same style of mask
        run_update(2, 1, 1'b1, 32'h0F30_5A01, 7, 0, 0);
        // R5: sparse walk with no enabled word
        run_update(0, 1, 1'b1, '0, 11, 0, 0);
        // R3: sparse walk, all bytes enabled
        run_update(3, 0, 1'b1, '1, 13, 0, 0);
        // R7: full walk with empty masks rewrites old data
        run_update(3, 1, 1'b0, '0, 17, 0, 0);
        // R3: only the last word, then only the first word
        run_update(1, 1, 1'b1, 32'h9000_0000, 19, 0, 0);
        run_update(2, 0, 1'b1, 32'h0000_0006, 23, 0, 0);
        // R6: start mid-walk and in the done cycle are ignored
        run_update(0, 0, 1'b0, 32'h1234_5678, 29, 5, 1);
        run_update(2, 1, 1'b1, 32'h00C0_0300, 31, 2, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule